// File: doc/BRIEF.md
# Selectable Power-Up Release Sequencer

This block decides when a custom logic device leaves power-up. A raw power-on-reset pulse always puts the device into a held state. In that state a synchronous reset is asserted to user logic, and a configuration-done pin is driven low. When the held state ends, the reset is released and the pin goes to high impedance, so that an external pull-up supplies the high level. The pin is modelled as an output-enable plus a value, and the value is always zero.

A two-bit mode select chooses the release policy, and the block takes its value only while power-on reset is active. The first policy releases as soon as the reset pulse ends. The second holds for a fixed delay, nominally 50 ms, counted in system clocks. The third emulates a serial configuration load. In that mode the block counts rising edges of an external configuration clock, but only while the active-low program control is high (a load is in progress). It releases after a parameterised number of such edges. The configuration inputs are plain control pins. They are not a data stream, so there is no valid/ready handshake.

Top module: `pwrup_release_seq`

## Requirements
- R1: The mode select is decoded as follows: 2'b00 = immediate, 2'b01 = delayed, 2'b10 = emulation, 2'b11 = immediate.
- R2: At every clock edge that samples `por_raw` high, the block enters the held state (`user_rst`=1, `cdone_oe`=1) and clears all counters.
- R3: In immediate mode, release happens on the first clock edge that samples `por_raw` low.
- R4: In delayed mode, release happens on the HOLD_CYCLES-th clock edge after `por_raw` is sampled low. By default HOLD_CYCLES = CLK_HZ/1000*HOLD_MS, and it can be overridden directly.
- R5: In immediate and delayed modes, `cfg_dclk` and `cfg_prog_n` have no effect on when release happens.
- R6: `user_rst` and `cdone_oe` change on the same clock edge and are always equal. `cdone_val` is always 0.
- R7: In emulation mode, each rising edge of `cfg_dclk` is counted only while `cfg_prog_n` is high. Both inputs pass through a two-flop synchronizer. Release happens on the edge that counts the EMU_CYCLES-th rising edge.
- R8: In emulation mode, a low level on `cfg_prog_n` clears the edge count, so a full EMU_CYCLES edges are needed after it returns high.
- R9: The mode is captured only on edges that sample `por_raw` high. Changes to `mode_sel` at any other time have no effect.
- R10: A new power-on-reset pulse after release returns the block to the held state and restarts the chosen policy from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_raw | input | 1 | Raw power-on reset, active high, sampled synchronously |
| mode_sel | input | 2 | Release policy select |
| cfg_prog_n | input | 1 | Active-low program control; high means a load is in progress |
| cfg_dclk | input | 1 | Configuration clock from the loading host (asynchronous) |
| user_rst | output | 1 | Synchronous reset to user logic, active high |
| cdone_oe | output | 1 | Configuration-done output enable; 1 drives the pin |
| cdone_val | output | 1 | Configuration-done driven value, always 0 |

## Verification
Some behaviours hold on every cycle, and the assertions check them there. Power-on reset forces the held state on the next edge. The captured mode never moves while reset is low. The delay counter never passes its terminal value. The edge count never changes except on a qualified clock edge. Any release in delayed or emulation mode must be preceded by that mode's done condition. Other behaviours appear only over whole scenarios, so only the bench can show them: the exact release edge in each mode, the immunity of the timed modes to toggling configuration inputs, the restart of the emulated load by the program control, and the full restart after a repeated reset pulse.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [1:0] {
    MODE_NOW     = 2'b00,
    MODE_WAIT    = 2'b01,
    MODE_EMU     = 2'b10,
    MODE_NOW_ALT = 2'b11
  } rel_mode_t;
endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk) chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrup_delay_timer.sv
module pwrup_delay_timer #(
  parameter int HOLD_CYCLES = 20
) (
  input  logic clk,
  input  logic clr_i,
  output logic done_o
);
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr_i)              cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  // R4: the hold counter never runs past its terminal value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (clr_i)
    cnt_q <= LAST);
endmodule

// File: rtl/pwrup_emu_counter.sv
module pwrup_emu_counter #(
  parameter int EMU_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_i,
  input  logic dclk_i,
  input  logic prog_n_i,
  output logic done_o
);
  localparam int CW = (EMU_CYCLES > 1) ? $clog2(EMU_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(EMU_CYCLES - 1);

  logic dclk_s, prog_s, dclk_prev_q, rise, loading;
  logic [CW-1:0] cnt_q;

  pwrup_sync #(.STAGES(SYNC_STAGES)) u_dclk_sync (
    .clk(clk), .d_i(dclk_i), .q_o(dclk_s));
  pwrup_sync #(.STAGES(SYNC_STAGES)) u_prog_sync (
    .clk(clk), .d_i(prog_n_i), .q_o(prog_s));

  always_ff @(posedge clk) dclk_prev_q <= dclk_s;

  assign rise    = dclk_s & ~dclk_prev_q;
  assign loading = prog_s;

  always_ff @(posedge clk) begin
    if (clr_i || !loading)          cnt_q <= '0;
    else if (rise && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = loading & rise & (cnt_q == LAST);

  // R7: the count only moves on a qualified configuration clock edge
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (clr_i)
    (loading && !rise) |=> $stable(cnt_q));

  // R8: a low program control leaves the count at zero
  p_prog_clear_r8: assert property (@(posedge clk) disable iff (clr_i)
    !loading |=> (cnt_q == '0));
endmodule

// File: rtl/pwrup_release_seq.sv
module pwrup_release_seq
  import pwrup_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int HOLD_MS     = 50,
  parameter int HOLD_CYCLES = CLK_HZ / 1000 * HOLD_MS,
  parameter int EMU_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_raw,
  input  logic [1:0] mode_sel,
  input  logic       cfg_prog_n,
  input  logic       cfg_dclk,
  output logic       user_rst,
  output logic       cdone_oe,
  output logic       cdone_val
);
  rel_mode_t mode_q;
  logic      released_q;
  logic      tmr_done, emu_done, release_now;

  always_ff @(posedge clk) begin
    if (por_raw) mode_q <= rel_mode_t'(mode_sel);
  end

  pwrup_delay_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .clr_i(por_raw), .done_o(tmr_done));

  pwrup_emu_counter #(.EMU_CYCLES(EMU_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_emu (
    .clk(clk), .clr_i(por_raw), .dclk_i(cfg_dclk), .prog_n_i(cfg_prog_n),
    .done_o(emu_done));

  always_comb begin
    unique case (mode_q)
      MODE_WAIT: release_now = tmr_done;
      MODE_EMU:  release_now = emu_done;
      default:   release_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_raw)         released_q <= 1'b0;
    else if (release_now) released_q <= 1'b1;
  end

  assign user_rst  = ~released_q;
  assign cdone_oe  = ~released_q;
  assign cdone_val = 1'b0;

  // R2: a sampled power-on reset always yields the held state
  p_por_holds_r2: assert property (@(posedge clk)
    por_raw |=> (user_rst && cdone_oe));

  // R9: the captured mode only moves under power-on reset
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (por_raw)
    !por_raw |=> $stable(mode_q));

  // R4: a delayed-mode release is preceded by the timer's terminal count
  p_wait_release_r4: assert property (@(posedge clk) disable iff (por_raw)
    ($fell(user_rst) && mode_q == MODE_WAIT) |-> $past(tmr_done));

  // R7: an emulation-mode release is preceded by the final counted edge
  p_emu_release_r7: assert property (@(posedge clk) disable iff (por_raw)
    ($fell(user_rst) && mode_q == MODE_EMU) |-> $past(emu_done));
endmodule

// File: tb/pwrup_release_seq_tb.sv
module pwrup_release_seq_tb_top;
  localparam int HOLD = 20;
  localparam int EMU  = 4;

  logic clk = 1'b0;
  logic por_raw = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic cfg_prog_n = 1'b0;
  logic cfg_dclk = 1'b0;
  logic user_rst, cdone_oe, cdone_val;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwrup_release_seq #(.HOLD_CYCLES(HOLD), .EMU_CYCLES(EMU)) dut_i (
    .clk(clk), .por_raw(por_raw), .mode_sel(mode_sel),
    .cfg_prog_n(cfg_prog_n), .cfg_dclk(cfg_dclk),
    .user_rst(user_rst), .cdone_oe(cdone_oe), .cdone_val(cdone_val));

  // vector: {mode[1:0], edges to release[7:0]}  (R1, R3, R4)
  localparam logic [9:0] VEC [4] = '{
    {2'b00, 8'd1}, {2'b11, 8'd1}, {2'b01, 8'(HOLD)}, {2'b00, 8'd1}};

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6: pin value always zero, enable always tracks reset
  task automatic check_state(input logic held, input string req);
    check(user_rst == held, req, int'(user_rst), int'(held));
    check(cdone_oe == user_rst && cdone_val == 1'b0, "R6",
          int'({cdone_oe, cdone_val}), int'({user_rst, 1'b0}));
  endtask

  task automatic do_por(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    por_raw  = 1'b1;
    repeat (3) @(negedge clk);
    check_state(1'b1, "R2");
    por_raw = 1'b0;
  endtask

  task automatic pulse();
    cfg_dclk = 1'b1;
    repeat (2) @(negedge clk);
    cfg_dclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200_000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check_state(1'b1, "R2");

    // R1 R3 R4: table walk
    foreach (VEC[i]) begin
      do_por(VEC[i][9:8]);
      if (VEC[i][7:0] > 8'd1) begin
        repeat (int'(VEC[i][7:0]) - 1) @(negedge clk);
        check_state(1'b1, "R4");
      end
      @(negedge clk);
      check_state(1'b0, (VEC[i][9:8] == 2'b01) ? "R4" : "R3");
    end

    // R9: mode change after release has no effect
    mode_sel = 2'b01;
    repeat (5) @(negedge clk);
    check_state(1'b0, "R9");

    // R9: mode change during delayed hold does not shorten it
    do_por(2'b01);
    mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    check_state(1'b1, "R9");
    repeat (HOLD - 3) @(negedge clk);
    check_state(1'b0, "R9");

    // R5: configuration inputs toggling in delayed mode
    cfg_prog_n = 1'b1;
    do_por(2'b01);
    repeat (4) pulse();
    repeat (HOLD - 17) @(negedge clk);
    check_state(1'b1, "R5");
    @(negedge clk);
    check_state(1'b0, "R5");

    // R5: immediate mode with program control low
    cfg_prog_n = 1'b0;
    do_por(2'b00);
    @(negedge clk);
    check_state(1'b0, "R5");

    // R7: edges ignored while program control low
    do_por(2'b10);
    repeat (EMU + 2) pulse();
    check_state(1'b1, "R7");

    // R8: dropping program control restarts the count
    cfg_prog_n = 1'b1;
    repeat (3) @(negedge clk);
    repeat (EMU - 1) pulse();
    cfg_prog_n = 1'b0;
    repeat (3) @(negedge clk);
    cfg_prog_n = 1'b1;
    repeat (3) @(negedge clk);
    repeat (EMU - 1) pulse();
    check_state(1'b1, "R8");
    pulse();
    check_state(1'b0, "R7");

    // R10: fresh reset after release restarts emulation
    do_por(2'b10);
    repeat (3) @(negedge clk);
    repeat (EMU - 1) pulse();
    check_state(1'b1, "R10");
    pulse();
    check_state(1'b0, "R10");

    // R10: fresh reset restarts the full delay
    do_por(2'b01);
    repeat (HOLD - 1) @(negedge clk);
    check_state(1'b1, "R10");
    @(negedge clk);
    check_state(1'b0, "R10");

    finish_run();
  end
endmodule